// File: doc/BRIEF.md
# Branch Target and Condition Unit

This unit settles each branch for the fetch stage of a 32-bit RISC core. For every branch presented to it, it states whether the branch is taken and which address to fetch next. It also owns the link register and the count register. A branch may be an unconditional displacement branch, a conditional displacement branch, or a conditional branch whose target comes from the link or the count register. The condition combines an optional test of one condition-register bit with an optional decrement-and-zero-test of the count register. Displacement targets are either relative to the branch's own address or absolute.

Each branch is presented for one cycle with its decoded kind, the low 26 bits of the instruction word, its address and the condition register. The result appears on the cycle after. A small two-state machine tracks whether a result is being shown. It has the states IDLE and RESOLVED. The transition IDLE->RESOLVED fires on a presented branch. RESOLVED->RESOLVED fires on a branch presented back to back. RESOLVED->IDLE fires when no branch arrives. Separate write ports load the link and count registers.

Top module: `br_resolve_unit`

## Requirements
- R1: With `br_kind`=0 (unconditional), LI = `br_fields[25:2]` is shifted left by two and sign-extended from bit 25. With AA = `br_fields[1]` = 0 the target is `br_cia` plus that displacement, modulo 2^32. The branch is always taken.
- R2: With `br_kind`=1 (conditional displacement), BD = `br_fields[15:2]` is shifted left by two and sign-extended from bit 15. With AA=0 it is added to `br_cia`, modulo 2^32.
- R3: With AA=1, a displacement target is the sign-extended displacement alone, for both `br_kind` 0 and 1.
- R4: With `br_kind`=2 the target is the link register, and with `br_kind`=3 it is the count register. In both cases the value is taken before this branch updates it, and its two low bits are forced to 0. BD and AA are ignored.
- R5: For the conditional kinds, BO = `br_fields[25:21]` with BO[0]=`br_fields[25]`, and BI = `br_fields[20:16]`. When BO[0]=0, the condition passes only if `cr_bits[31-BI]` equals BO[1]=`br_fields[24]`. BI=0 names the most significant bit.
- R6: When BO[0]=1, the condition-register test is skipped and BI has no effect.
- R7: When BO[2]=`br_fields[23]`=0, the count register is decremented. With BO[3]=`br_fields[22]`=0 the decremented value must be nonzero for the condition to pass. With BO[3]=1 it must be zero.
- R8: When BO[2]=1, the count register is unchanged and does not take part in the condition.
- R9: A conditional branch is taken only if both tests pass or are skipped. A branch that is not taken gives `br_cia`+4 as the next address.
- R10: When LK = `br_fields[0]` is 1, the link register becomes `br_cia`+4 whether or not the branch is taken. A decrement is kept whether or not the branch is taken.
- R11: `lr_we` and `ctr_we` load their registers at the next edge. When a load falls in the same cycle as a branch update of the same register, the load wins.
- R12: Reset clears both registers and all result outputs. `res_valid` is high in the cycle after each cycle in which `br_valid` was high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A branch is presented this cycle |
| br_kind | input | 2 | 0 unconditional, 1 conditional displacement, 2 via link, 3 via count |
| br_fields | input | 26 | Low 26 bits of the branch instruction |
| br_cia | input | 32 | Address of the branch instruction |
| cr_bits | input | 32 | Condition register |
| lr_we | input | 1 | Load the link register |
| lr_wdata | input | 32 | Link register load value |
| ctr_we | input | 1 | Load the count register |
| ctr_wdata | input | 32 | Count register load value |
| res_valid | output | 1 | Result of the previous cycle's branch is shown |
| res_taken | output | 1 | That branch is taken |
| res_next_pc | output | 32 | Next fetch address |
| lr_value | output | 32 | Current link register |
| ctr_value | output | 32 | Current count register |

## Verification
The hardest case to reach is the count loop crossing zero. That includes the wrap from 0 to all ones, and a count load that collides with a decrement in the same cycle. The stimulus loads a small count and then issues decrementing branches back to back under both BO[3] senses, so that the taken flag flips on exactly the predicted iteration. One decrementing branch is issued with a count load in the same cycle. The address wrap is forced with addresses near the top of the space and displacements near their extremes. A model in the bench holds its own link and count copies, and each branch's expected result is queued for comparison when the design shows it.

// File: rtl/br_pkg.sv
package br_pkg;
    typedef enum logic [1:0] {
        BK_DISP_U    = 2'd0,
        BK_DISP_C    = 2'd1,
        BK_VIA_LINK  = 2'd2,
        BK_VIA_COUNT = 2'd3
    } br_kind_e;

    typedef enum logic {
        ST_IDLE     = 1'b0,
        ST_RESOLVED = 1'b1
    } res_state_e;

    localparam int FIELDS_W = 26;
    localparam int LI_W     = 24;
    localparam int BD_W     = 14;
endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
    import br_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  br_kind_e            kind,
    input  logic [3:0]          bo_hi,     // BO[0..3], BO[0] at bit 3
    input  logic [4:0]          bi,
    input  logic [31:0]         cr,
    input  logic [ADDR_W-1:0]   ctr,
    output logic                cond_ok,
    output logic                ctr_upd,
    output logic [ADDR_W-1:0]   ctr_next
);
    logic skip_cr, skip_ctr, want_zero, want_bit;
    logic cr_bit, cr_pass, ctr_pass, is_cond;

    assign skip_cr   = bo_hi[3];
    assign want_bit  = bo_hi[2];
    assign skip_ctr  = bo_hi[1];
    assign want_zero = bo_hi[0];
    assign is_cond   = (kind != BK_DISP_U);

    always_comb begin
        cr_bit   = cr[5'd31 - bi];
        cr_pass  = skip_cr || (cr_bit == want_bit);
        ctr_next = ctr - {{(ADDR_W-1){1'b0}}, 1'b1};
        ctr_upd  = is_cond && !skip_ctr;
        if (skip_ctr)
            ctr_pass = 1'b1;
        else if (want_zero)
            ctr_pass = (ctr_next == '0);
        else
            ctr_pass = (ctr_next != '0);
        cond_ok = !is_cond || (cr_pass && ctr_pass);
    end

    always_comb begin
        if (!is_cond) AST_UNCOND_NO_DEC: assert (!ctr_upd && cond_ok); // R1
    end
endmodule

// File: rtl/br_target_gen.sv
module br_target_gen
    import br_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  br_kind_e               kind,
    input  logic [FIELDS_W-1:0]    fields,
    input  logic [ADDR_W-1:0]      cia,
    input  logic [ADDR_W-1:0]      lr,
    input  logic [ADDR_W-1:0]      ctr,
    output logic [ADDR_W-1:0]      target
);
    localparam int LONG_W  = LI_W + 2;
    localparam int SHORT_W = BD_W + 2;
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~{{(ADDR_W-2){1'b0}}, 2'b11};

    logic [LI_W-1:0]   li;
    logic [BD_W-1:0]   bd;
    logic              aa;
    logic [ADDR_W-1:0] disp_long, disp_short, disp, base;

    assign li = fields[LI_W+1:2];
    assign bd = fields[BD_W+1:2];
    assign aa = fields[1];

    assign disp_long  = {{(ADDR_W-LONG_W){li[LI_W-1]}}, li, 2'b00};
    assign disp_short = {{(ADDR_W-SHORT_W){bd[BD_W-1]}}, bd, 2'b00};

    always_comb begin
        disp = (kind == BK_DISP_U) ? disp_long : disp_short;
        base = aa ? '0 : cia;
        unique case (kind)
            BK_DISP_U, BK_DISP_C: target = base + disp;
            BK_VIA_LINK:          target = lr & ALIGN_MASK;
            BK_VIA_COUNT:         target = ctr & ALIGN_MASK;
            default:              target = base + disp;
        endcase
    end

    always_comb begin
        if (kind == BK_VIA_LINK || kind == BK_VIA_COUNT)
            AST_IND_LOW_ZERO: assert (target[1:0] == 2'b00); // R4
    end
endmodule

// File: rtl/br_link_count.sv
module br_link_count #(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd_en,
    input  logic                link_en,
    input  logic [ADDR_W-1:0]   link_val,
    input  logic                ctr_upd,
    input  logic [ADDR_W-1:0]   ctr_next,
    input  logic                lr_we,
    input  logic [ADDR_W-1:0]   lr_wdata,
    input  logic                ctr_we,
    input  logic [ADDR_W-1:0]   ctr_wdata,
    output logic [ADDR_W-1:0]   lr_q,
    output logic [ADDR_W-1:0]   ctr_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_q  <= '0;
            ctr_q <= '0;
        end else begin
            if (lr_we)
                lr_q <= lr_wdata;
            else if (upd_en && link_en)
                lr_q <= link_val;
            if (ctr_we)
                ctr_q <= ctr_wdata;
            else if (upd_en && ctr_upd)
                ctr_q <= ctr_next;
        end
    end

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_we |=> ctr_q == $past(ctr_wdata)); // R11
    AST_CTR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctr_we && !(upd_en && ctr_upd)) |=> $stable(ctr_q)); // R8
endmodule

// File: rtl/br_resolve_unit.sv
module br_resolve_unit
    import br_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                br_valid,
    input  logic [1:0]          br_kind,
    input  logic [25:0]         br_fields,
    input  logic [ADDR_W-1:0]   br_cia,
    input  logic [31:0]         cr_bits,
    input  logic                lr_we,
    input  logic [ADDR_W-1:0]   lr_wdata,
    input  logic                ctr_we,
    input  logic [ADDR_W-1:0]   ctr_wdata,
    output logic                res_valid,
    output logic                res_taken,
    output logic [ADDR_W-1:0]   res_next_pc,
    output logic [ADDR_W-1:0]   lr_value,
    output logic [ADDR_W-1:0]   ctr_value
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    br_kind_e          kind;
    res_state_e        state_q, state_d;
    logic              cond_ok, ctr_upd;
    logic [ADDR_W-1:0] ctr_next, target, seq_pc;
    logic [ADDR_W-1:0] lr_q, ctr_q;
    logic              taken_q, ind_q;
    logic [ADDR_W-1:0] next_q;

    assign kind   = br_kind_e'(br_kind);
    assign seq_pc = br_cia + STEP;

    br_cond_eval #(.ADDR_W(ADDR_W)) u_cond (
        .kind     (kind),
        .bo_hi    (br_fields[25:22]),
        .bi       (br_fields[20:16]),
        .cr       (cr_bits),
        .ctr      (ctr_q),
        .cond_ok  (cond_ok),
        .ctr_upd  (ctr_upd),
        .ctr_next (ctr_next)
    );

    br_target_gen #(.ADDR_W(ADDR_W)) u_tgt (
        .kind   (kind),
        .fields (br_fields),
        .cia    (br_cia),
        .lr     (lr_q),
        .ctr    (ctr_q),
        .target (target)
    );

    br_link_count #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (br_valid),
        .link_en   (br_fields[0]),
        .link_val  (seq_pc),
        .ctr_upd   (ctr_upd),
        .ctr_next  (ctr_next),
        .lr_we     (lr_we),
        .lr_wdata  (lr_wdata),
        .ctr_we    (ctr_we),
        .ctr_wdata (ctr_wdata),
        .lr_q      (lr_q),
        .ctr_q     (ctr_q)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     state_d = br_valid ? ST_RESOLVED : ST_IDLE;
            ST_RESOLVED: state_d = br_valid ? ST_RESOLVED : ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_q <= 1'b0;
            next_q  <= '0;
            ind_q   <= 1'b0;
        end else if (br_valid) begin
            taken_q <= cond_ok;
            next_q  <= cond_ok ? target : seq_pc;
            ind_q   <= (kind == BK_VIA_LINK) || (kind == BK_VIA_COUNT);
        end
    end

    // outputs
    always_comb begin
        res_valid   = (state_q == ST_RESOLVED);
        res_taken   = taken_q;
        res_next_pc = next_q;
        lr_value    = lr_q;
        ctr_value   = ctr_q;
    end

    AST_RES_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> res_valid); // R12
    AST_RES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |=> !res_valid); // R12
    AST_UNCOND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_kind == 2'd0) |=> res_taken); // R1
    AST_NOT_TAKEN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> (res_taken || res_next_pc == $past(br_cia) + STEP)); // R9
    AST_CR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_kind != 2'd0 && !br_fields[25]
         && cr_bits[5'd31 - br_fields[20:16]] != br_fields[24]) |=> !res_taken); // R5
    AST_LINK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_fields[0] && !lr_we) |=> lr_value == $past(br_cia) + STEP); // R10
    AST_CTR_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_kind != 2'd0 && !br_fields[23] && !ctr_we)
        |=> ctr_value == $past(ctr_value) - ADDR_W'(1)); // R7
    AST_IND_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_taken && ind_q) |-> res_next_pc[1:0] == 2'b00); // R4
endmodule

// File: tb/tb_br_resolve_unit.sv
`timescale 1ns/1ps
module tb_br_resolve_unit;
    typedef struct packed {
        logic        taken;
        logic [31:0] next;
        logic [31:0] lr;
        logic [31:0] ctr;
        logic [7:0]  tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0;
    logic [1:0]  br_kind = 2'd0;
    logic [25:0] br_fields = '0;
    logic [31:0] br_cia = '0;
    logic [31:0] cr_bits = '0;
    logic        lr_we = 1'b0;
    logic [31:0] lr_wdata = '0;
    logic        ctr_we = 1'b0;
    logic [31:0] ctr_wdata = '0;
    logic        res_valid, res_taken;
    logic [31:0] res_next_pc, lr_value, ctr_value;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    exp_t sb[$];
    logic [31:0] m_lr = '0;
    logic [31:0] m_ctr = '0;

    always #2 clk = ~clk;

    br_resolve_unit dut (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_kind(br_kind),
        .br_fields(br_fields), .br_cia(br_cia), .cr_bits(cr_bits),
        .lr_we(lr_we), .lr_wdata(lr_wdata), .ctr_we(ctr_we), .ctr_wdata(ctr_wdata),
        .res_valid(res_valid), .res_taken(res_taken), .res_next_pc(res_next_pc),
        .lr_value(lr_value), .ctr_value(ctr_value)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [25:0] f_uncond(input logic [23:0] li, input logic aa, input logic lk);
        return {li, aa, lk};
    endfunction

    function automatic logic [25:0] f_cond(input logic [4:0] bo, input logic [4:0] bi,
                                           input logic [13:0] bd, input logic aa, input logic lk);
        return {bo, bi, bd, aa, lk};
    endfunction

    // driver: compute expectation from the requirements, push it, present the branch
    task automatic issue(input string req, input logic [1:0] kind, input logic [25:0] f,
                         input logic [31:0] cia, input logic [31:0] cr,
                         input logic cw, input logic [31:0] cv);
        logic cr_ok, ctr_ok, taken;
        logic [31:0] tgt, nctr, disp;
        exp_t e;
        cr_ok = 1'b1; ctr_ok = 1'b1; nctr = m_ctr;
        if (kind != 2'd0) begin
            if (!f[25]) cr_ok = (cr[31 - int'(f[20:16])] == f[24]);
            if (!f[23]) begin
                nctr = m_ctr - 32'd1;
                ctr_ok = f[22] ? (nctr == 32'd0) : (nctr != 32'd0);
            end
        end
        case (kind)
            2'd0: begin disp = {{6{f[25]}}, f[25:2], 2'b00}; tgt = (f[1] ? 32'd0 : cia) + disp; end
            2'd1: begin disp = {{16{f[15]}}, f[15:2], 2'b00}; tgt = (f[1] ? 32'd0 : cia) + disp; end
            2'd2: tgt = {m_lr[31:2], 2'b00};
            default: tgt = {m_ctr[31:2], 2'b00};
        endcase
        taken = cr_ok && ctr_ok;
        m_ctr = cw ? cv : nctr;
        if (f[0]) m_lr = cia + 32'd4;
        e.taken = taken;
        e.next  = taken ? tgt : cia + 32'd4;
        e.lr    = m_lr;
        e.ctr   = m_ctr;
        e.tag   = 8'(req.atoi());
        sb.push_back(e);
        br_valid = 1'b1; br_kind = kind; br_fields = f; br_cia = cia; cr_bits = cr;
        ctr_we = cw; ctr_wdata = cv;
        @(negedge clk);
        br_valid = 1'b0; ctr_we = 1'b0;
    endtask

    task automatic load_regs(input logic [31:0] lv, input logic [31:0] cv);
        lr_we = 1'b1; lr_wdata = lv; ctr_we = 1'b1; ctr_wdata = cv;
        m_lr = lv; m_ctr = cv;
        @(negedge clk);
        lr_we = 1'b0; ctr_we = 1'b0;
        check("R11 lr load", lr_value, lv);
        check("R11 ctr load", ctr_value, cv);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R12 res_valid low", {31'd0, res_valid}, 32'd0);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (sb.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R12: unexpected result actual 1 expected 0");
            end else begin
                exp_t e;
                string r;
                e = sb.pop_front();
                r = $sformatf("R%0d", e.tag);
                check({r, " taken"}, {31'd0, res_taken}, {31'd0, e.taken});
                check({r, " next"},  res_next_pc, e.next);
                check({r, " lr"},    lr_value, e.lr);
                check({r, " ctr"},   ctr_value, e.ctr);
            end
        end
    end

    initial begin
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 reset valid", {31'd0, res_valid}, 32'd0);
        check("R12 reset next", res_next_pc, 32'd0);
        check("R12 reset lr", lr_value, 32'd0);
        check("R12 reset ctr", ctr_value, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        load_regs(32'h0000_1003, 32'd3);

        // R1 relative forward, backward, wrap
        issue("1", 2'd0, f_uncond(24'h000010, 1'b0, 1'b0), 32'h0000_2000, '0, 1'b0, '0);
        issue("1", 2'd0, f_uncond(24'hFFFFF0, 1'b0, 1'b0), 32'h0000_2000, '0, 1'b0, '0);
        issue("1", 2'd0, f_uncond(24'h000008, 1'b0, 1'b1), 32'hFFFF_FFF0, '0, 1'b0, '0);
        issue("1", 2'd0, f_uncond(24'h800000, 1'b0, 1'b0), 32'h0000_0100, '0, 1'b0, '0);
        // R3 absolute
        issue("3", 2'd0, f_uncond(24'hFFFFFF, 1'b1, 1'b0), 32'h1234_5678, '0, 1'b0, '0);
        issue("3", 2'd1, f_cond(5'b10100, 5'd0, 14'h2000, 1'b1, 1'b0), 32'h4000_0000, '0, 1'b0, '0);
        idle(1);
        // R2 conditional relative, always-true BO, wrap backward
        issue("2", 2'd1, f_cond(5'b10100, 5'd0, 14'h0040, 1'b0, 1'b0), 32'h0000_8000, '0, 1'b0, '0);
        issue("2", 2'd1, f_cond(5'b10100, 5'd0, 14'h3FF0, 1'b0, 1'b0), 32'h0000_0010, '0, 1'b0, '0);
        // R5 CR test pass and fail; BI=0 selects bit 31
        issue("5", 2'd1, f_cond(5'b01100, 5'd0, 14'h0010, 1'b0, 1'b0), 32'h0000_1000, 32'h8000_0000, 1'b0, '0);
        issue("5", 2'd1, f_cond(5'b01100, 5'd31, 14'h0010, 1'b0, 1'b0), 32'h0000_1000, 32'h8000_0000, 1'b0, '0);
        issue("5", 2'd1, f_cond(5'b00100, 5'd31, 14'h0010, 1'b0, 1'b0), 32'h0000_1000, 32'h8000_0000, 1'b0, '0);
        // R6 CR skipped, BI irrelevant
        issue("6", 2'd1, f_cond(5'b11100, 5'd7, 14'h0010, 1'b0, 1'b0), 32'h0000_1000, 32'h0000_0000, 1'b0, '0);
        idle(1);
        // R7 count loop: ctr 3 -> taken, taken, not taken (wants nonzero)
        issue("7", 2'd1, f_cond(5'b10000, 5'd0, 14'h3FFC, 1'b0, 1'b0), 32'h0000_3000, '0, 1'b0, '0);
        issue("7", 2'd1, f_cond(5'b10000, 5'd0, 14'h3FFC, 1'b0, 1'b0), 32'h0000_3000, '0, 1'b0, '0);
        issue("9", 2'd1, f_cond(5'b10000, 5'd0, 14'h3FFC, 1'b0, 1'b0), 32'h0000_3000, '0, 1'b0, '0);
        // R7 wrap 0 -> all ones, wants zero -> not taken
        issue("7", 2'd1, f_cond(5'b10010, 5'd0, 14'h0004, 1'b0, 1'b0), 32'h0000_3000, '0, 1'b0, '0);
        load_regs(32'h0000_1003, 32'd1);
        issue("7", 2'd1, f_cond(5'b10010, 5'd0, 14'h0004, 1'b0, 1'b0), 32'h0000_3000, '0, 1'b0, '0);
        // R8 no decrement
        issue("8", 2'd1, f_cond(5'b10110, 5'd0, 14'h0004, 1'b0, 1'b0), 32'h0000_3000, '0, 1'b0, '0);
        idle(1);
        // R4 via link with LK (old LR target, low bits cleared)
        issue("4", 2'd2, f_cond(5'b10100, 5'd3, 14'h1234, 1'b1, 1'b1), 32'h0000_5000, '0, 1'b0, '0);
        load_regs(32'h0000_1000, 32'h0000_7006);
        issue("4", 2'd3, f_cond(5'b10100, 5'd0, 14'h0abc, 1'b0, 1'b0), 32'h0000_6000, '0, 1'b0, '0);
        // R10 not taken with LK and decrement still committed
        issue("10", 2'd1, f_cond(5'b00000, 5'd0, 14'h0100, 1'b0, 1'b1), 32'h0000_9000, 32'h8000_0000, 1'b0, '0);
        // R11 load colliding with decrement: load wins
        issue("11", 2'd1, f_cond(5'b10000, 5'd0, 14'h0100, 1'b0, 1'b0), 32'h0000_9100, '0, 1'b1, 32'd42);
        idle(2);
        check("R11 ctr after collision", ctr_value, 32'd42);
        check("R12 queue drained", 32'(sb.size()), 32'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule